// File: doc/BRIEF.md
# Colour Lookup Table Register Port

This block holds a colour lookup table and gives a processor a narrow 32-bit register window onto it. The table has 256 main entries and 4 overlay entries placed above them, giving 260 entries in all. Each entry stores an 8-bit red, green and blue component. Software first selects an entry, then moves through its components one bus word at a time. Each word carries one component in its top byte. After the blue component, the selection moves on to the next entry, so a whole palette can be loaded by one stream of data words.

A single phase counter sets which component the next access touches, and reads and writes share it. A read therefore continues the sequence wherever the last write left it. A second data offset sends writes to the overlay bank: the low two bits of the current index pick the overlay slot. A pixel pipeline reads the table through a separate combinational lookup port, which takes a 9-bit entry number and returns the packed 24-bit colour.

Top module: `clut_regport`

## Requirements
- R1: After reset every component of every entry is 0, except entries 255, 256 and 258, which are white (0xFFFFFF). The index and the phase are 0, so the first read returns the red component of entry 0.
- R2: A write to byte offset 0x0 loads the index from data bits 31:24 and returns the phase to red. This also applies in the middle of a component sequence.
- R3: Each write to offset 0x4 stores data bits 31:24 into the component given by the phase (0 = red, 1 = green, 2 = blue) of the indexed main entry. The phase then moves 0→1→2→0. Data bits 23:0 are discarded.
- R4: Each access that completes the blue component increments the index modulo 256 (255 wraps to 0).
- R5: A write to offset 0xC follows the same phase sequence, but its target is overlay entry 256 + index[1:0]. The indexed main entry is left unchanged, and the index still advances after blue.
- R6: A read request at any offset returns, one cycle later with rsp_valid high, the current-phase component of the indexed main entry in bits 31:24 with zeros in bits 23:0. rsp_valid is high only in the cycle after a read request.
- R7: A write to any offset other than 0x0, 0x4 and 0xC (for example 0x8 or 0x1) changes neither the table, the index nor the phase.
- R8: lut_rgb is {red, green, blue} of entry lut_sel, computed combinationally. It is 0 when lut_sel is 260 or more. A component write shows on lut_rgb one cycle after the write request.
- R9: Reads and writes advance one shared phase. A read that follows a red write returns the green component of the same entry, and a write after that read lands on blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Single-cycle bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset within the 16-byte window |
| req_wdata | input | 32 | Write data; component or index in bits 31:24 |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data, component in bits 31:24 |
| lut_sel | input | 9 | Entry number for the pixel lookup |
| lut_rgb | output | 24 | Colour of entry lut_sel as {red, green, blue} |

## Verification
A bus write and a pixel lookup of the same entry can fall in the same cycle. The bench holds lut_sel on an entry while it writes that entry's red component. It expects the old colour in the write cycle and the new red byte one cycle later. A read and a data write also compete for the one phase counter. The bench interleaves them on a single entry and judges every returned word and stored byte against its own model of the index and phase.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_e;

  localparam int NUM_COMP = 3;
  localparam logic [3:0] OFF_INDEX = 4'h0;
  localparam logic [3:0] OFF_MAIN  = 4'h4;
  localparam logic [3:0] OFF_OVL   = 4'hC;

  function automatic phase_e phase_next(phase_e p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  function automatic logic phase_last(phase_e p);
    return p == PH_BLU;
  endfunction

  // entries that come out of reset white: last main entry, overlay 0 and overlay 2
  function automatic logic white_at_reset(int e, int main_n);
    return (e == main_n - 1) || (e == main_n) || (e == main_n + 2);
  endfunction
endpackage

// File: rtl/clut_decode.sv
module clut_decode
  import clut_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [3:0] req_addr,
  output logic       wr_index,
  output logic       wr_main,
  output logic       wr_ovl,
  output logic       rd_step
);
  logic wr_any;
  assign wr_any   = req_valid && req_write;
  assign wr_index = wr_any && (req_addr == OFF_INDEX);
  assign wr_main  = wr_any && (req_addr == OFF_MAIN);
  assign wr_ovl   = wr_any && (req_addr == OFF_OVL);
  assign rd_step  = req_valid && !req_write;
endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output phase_e           phase,
  output logic             wrap_evt
);
  assign wrap_evt = step && !load && phase_last(phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (load) begin
      idx   <= load_val;
      phase <= PH_RED;
    end else if (step) begin
      phase <= phase_next(phase);
      if (phase_last(phase)) idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int OVL_N  = 4,
  parameter int COMP_W = 8,
  localparam int MAIN_N = 1 << IDX_W,
  localparam int N_ENT  = MAIN_N + OVL_N,
  localparam int ENT_W  = $clog2(N_ENT),
  localparam int RGB_W  = NUM_COMP * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ENT_W-1:0]  wr_entry,
  input  phase_e            wr_phase,
  input  logic [COMP_W-1:0] wr_val,
  input  logic [ENT_W-1:0]  bus_entry,
  output logic [RGB_W-1:0]  bus_rgb,
  input  logic [ENT_W-1:0]  lut_sel,
  output logic [RGB_W-1:0]  lut_rgb
);
  logic lut_ok;
  assign lut_ok = lut_sel < ENT_W'(N_ENT);

  // one plane per component; red occupies the top slice of the packed colour
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_plane
    localparam int LSB = (NUM_COMP - 1 - c) * COMP_W;
    logic [COMP_W-1:0] mem [N_ENT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int e = 0; e < N_ENT; e++)
          mem[e] <= white_at_reset(e, MAIN_N) ? '1 : '0;
      end else if (we && (wr_phase == phase_e'(c))) begin
        mem[wr_entry] <= wr_val;
      end
    end

    assign lut_rgb[LSB +: COMP_W] = lut_ok ? mem[lut_sel] : '0;
    assign bus_rgb[LSB +: COMP_W] = mem[bus_entry];
  end
endmodule

// File: rtl/clut_regport.sv
module clut_regport
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int OVL_N  = 4,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  localparam int MAIN_N = 1 << IDX_W,
  localparam int N_ENT  = MAIN_N + OVL_N,
  localparam int ENT_W  = $clog2(N_ENT),
  localparam int OVL_W  = $clog2(OVL_N),
  localparam int RGB_W  = NUM_COMP * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [ENT_W-1:0]  lut_sel,
  output logic [RGB_W-1:0]  lut_rgb
);
  logic              wr_index, wr_main, wr_ovl, rd_step, step, comp_we, wrap_evt;
  logic [IDX_W-1:0]  cur_idx;
  phase_e            cur_phase;
  logic [ENT_W-1:0]  wr_entry, bus_entry;
  logic [RGB_W-1:0]  bus_rgb;
  logic [COMP_W-1:0] wr_byte, rd_byte;
  logic              unused_low;

  function automatic logic [ENT_W-1:0] target_entry(logic ovl, logic [IDX_W-1:0] i);
    if (ovl) return ENT_W'(MAIN_N) + ENT_W'(i[OVL_W-1:0]);
    return ENT_W'(i);
  endfunction

  function automatic logic [COMP_W-1:0] pick_comp(logic [RGB_W-1:0] rgb, phase_e p);
    case (p)
      PH_RED:  return rgb[2*COMP_W +: COMP_W];
      PH_GRN:  return rgb[COMP_W +: COMP_W];
      default: return rgb[0 +: COMP_W];
    endcase
  endfunction

  assign wr_byte    = req_wdata[DATA_W-1 -: COMP_W];
  assign unused_low = ^req_wdata[DATA_W-COMP_W-1:0];

  clut_decode u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .wr_index(wr_index), .wr_main(wr_main), .wr_ovl(wr_ovl), .rd_step(rd_step)
  );

  assign comp_we = wr_main || wr_ovl;
  assign step    = comp_we || rd_step;

  clut_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(wr_index),
    .load_val(req_wdata[DATA_W-1 -: IDX_W]), .step(step),
    .idx(cur_idx), .phase(cur_phase), .wrap_evt(wrap_evt)
  );

  assign wr_entry  = target_entry(wr_ovl, cur_idx);
  assign bus_entry = target_entry(1'b0, cur_idx);

  clut_store #(.IDX_W(IDX_W), .OVL_N(OVL_N), .COMP_W(COMP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(comp_we), .wr_entry(wr_entry),
    .wr_phase(cur_phase), .wr_val(wr_byte), .bus_entry(bus_entry),
    .bus_rgb(bus_rgb), .lut_sel(lut_sel), .lut_rgb(lut_rgb)
  );

  assign rd_byte = pick_comp(bus_rgb, cur_phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_step;
      if (rd_step) rsp_rdata <= {rd_byte, {(DATA_W-COMP_W){1'b0}}};
    end
  end
endmodule

// File: rtl/clut_regport_chk.sv
module clut_regport_chk #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int ENT_W  = 9,
  parameter int N_ENT  = 260,
  parameter int RGB_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [3:0]        req_addr,
  input logic [COMP_W-1:0] wdata_hi,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ENT_W-1:0]  lut_sel,
  input logic [RGB_W-1:0]  lut_rgb,
  input logic [IDX_W-1:0]  idx,
  input logic [1:0]        phase,
  input logic              wrap_evt
);
  logic rd_req, wr_ign, wr_red_main;
  assign rd_req = req_valid && !req_write;
  assign wr_ign = req_valid && req_write &&
                  !(req_addr == 4'h0 || req_addr == 4'h4 || req_addr == 4'hC);
  assign wr_red_main = req_valid && req_write && req_addr == 4'h4 && phase == 2'd0;

  assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 4'h0) |=>
      (idx == $past(wdata_hi[COMP_W-1 -: IDX_W]) && phase == 2'd0));

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  assert_index_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && idx == '1) |=> idx == '0);

  assert_rsp_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  assert_no_spurious_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);

  assert_rsp_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata & {{COMP_W{1'b0}}, {(DATA_W-COMP_W){1'b1}}}) == '0);

  assert_ignored_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ign |=> ($stable(idx) && $stable(phase)));

  assert_lookup_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_red_main && lut_sel == ENT_W'(idx)) |=>
      (!$stable(lut_sel) || lut_rgb[RGB_W-1 -: COMP_W] == $past(wdata_hi)));

  assert_lookup_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_sel >= ENT_W'(N_ENT)) |-> lut_rgb == '0);
endmodule

bind clut_regport clut_regport_chk #(
  .IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W),
  .ENT_W(ENT_W), .N_ENT(N_ENT), .RGB_W(RGB_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .wdata_hi(req_wdata[DATA_W-1 -: COMP_W]),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .lut_sel(lut_sel),
  .lut_rgb(lut_rgb), .idx(cur_idx), .phase(cur_phase), .wrap_evt(wrap_evt)
);

// File: tb/clut_regport_bench.sv
`timescale 1ns/1ps
module clut_regport_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = 4'h0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [8:0]  lut_sel = '0;
  logic [23:0] lut_rgb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model
  int mr [260];
  int mg [260];
  int mb [260];
  int mi = 0;
  int mp = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  clut_regport u_clut_regport (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .lut_sel(lut_sel), .lut_rgb(lut_rgb)
  );

  function automatic int model_rgb(int e);
    if (e > 259) return 0;
    return (mr[e] << 16) | (mg[e] << 8) | mb[e];
  endfunction

  function automatic void model_advance();
    mp = mp + 1;
    if (mp == 3) begin
      mp = 0;
      mi = (mi + 1) % 256;
    end
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic do_req(bit wr, logic [3:0] off, logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = off;
    req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic bus_write(logic [3:0] off, logic [31:0] data);
    int e;
    int v;
    v = int'(data[31:24]);
    if (off == 4'h0) begin
      mi = v;
      mp = 0;
    end else if (off == 4'h4 || off == 4'hC) begin
      e = (off == 4'hC) ? 256 + (mi % 4) : mi;
      if (mp == 0) mr[e] = v;
      else if (mp == 1) mg[e] = v;
      else mb[e] = v;
      model_advance();
    end
    do_req(1'b1, off, data);
  endtask

  task automatic bus_read(logic [3:0] off, string tag);
    int v;
    v = (mp == 0) ? mr[mi] : (mp == 1) ? mg[mi] : mb[mi];
    exp_q.push_back(32'(v) << 24);
    tag_q.push_back(tag);
    model_advance();
    do_req(1'b0, off, 32'h0);
  endtask

  task automatic check_lut(int e, string tag);
    lut_sel = 9'(e);
    #1;
    check(tag, {8'h0, lut_rgb}, 32'(model_rgb(e)));
  endtask

  // monitor: compare each read response against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R6: unexpected response actual %h expected none", rsp_rdata);
      end else begin
        logic [31:0] ev;
        string tg;
        ev = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, rsp_rdata, ev);
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 260; e++) begin
      mr[e] = 0; mg[e] = 0; mb[e] = 0;
    end
    mr[255] = 255; mg[255] = 255; mb[255] = 255;
    mr[256] = 255; mg[256] = 255; mb[256] = 255;
    mr[258] = 255; mg[258] = 255; mb[258] = 255;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset contents
    check_lut(0,   "R1 entry 0");
    check_lut(254, "R1 entry 254");
    check_lut(255, "R1 entry 255");
    check_lut(256, "R1 entry 256");
    check_lut(257, "R1 entry 257");
    check_lut(258, "R1 entry 258");
    check_lut(259, "R1 entry 259");
    check_lut(300, "R8 out of range");
    check("R1 no response after reset", {31'h0, rsp_valid}, 32'h0);

    // R1/R6 first reads from entry 0, then R4 wrap from 255
    bus_read(4'h0, "R1 first read red");
    bus_read(4'h8, "R6 read green");
    bus_read(4'h4, "R6 read blue");
    bus_write(4'h0, 32'hFF00_0000);
    bus_read(4'h0, "R6 read white red");
    bus_read(4'h0, "R6 read white green");
    bus_read(4'h0, "R6 read white blue");
    bus_read(4'h0, "R4 wrapped to entry 0");

    // R3 component write sequence, low data bits discarded
    bus_write(4'h0, 32'h0A00_0000);
    bus_write(4'h4, 32'h11AB_CDEF);
    bus_write(4'h4, 32'h2212_3456);
    bus_write(4'h4, 32'h33FF_FFFF);
    check_lut(10, "R3 entry 10 colour");
    bus_write(4'h4, 32'h4400_0000);
    check_lut(11, "R4 advanced to entry 11");

    // R2 index reload in mid sequence
    bus_write(4'h0, 32'h1400_0000);
    bus_write(4'h4, 32'h5500_0000);
    bus_write(4'h0, 32'h1500_0000);
    bus_write(4'h4, 32'h6600_0000);
    check_lut(20, "R2 entry 20 partial");
    check_lut(21, "R2 entry 21 restarted red");

    // R5 overlay writes
    bus_write(4'h0, 32'h0700_0000);
    bus_write(4'hC, 32'hAA00_0000);
    bus_write(4'hC, 32'hBB00_0000);
    bus_write(4'hC, 32'hCC00_0000);
    check_lut(259, "R5 overlay 3");
    check_lut(7,   "R5 main entry untouched");
    bus_write(4'h4, 32'h7100_0000);
    check_lut(8,   "R5 index advanced after overlay blue");
    bus_write(4'h0, 32'hFD00_0000);
    bus_write(4'hC, 32'h0100_0000);
    check_lut(257, "R5 overlay 1");

    // R7 ignored offsets keep phase and table
    bus_write(4'h0, 32'h1E00_0000);
    bus_write(4'h4, 32'h1200_0000);
    bus_write(4'h8, 32'hFF00_0000);
    bus_write(4'h1, 32'hEE00_0000);
    bus_write(4'hF, 32'hDD00_0000);
    bus_write(4'h4, 32'h3400_0000);
    check_lut(30, "R7 phase kept across ignored writes");
    check_lut(31, "R7 neighbour untouched");

    // R9 shared phase between reads and writes
    bus_write(4'h0, 32'h2800_0000);
    bus_write(4'h4, 32'h9A00_0000);
    bus_read(4'h0, "R9 read after red write gives green");
    bus_write(4'h4, 32'h7700_0000);
    check_lut(40, "R9 write after read lands on blue");
    bus_read(4'h0, "R9 read continues at next entry");

    // R8 lookup and bus write of the same entry in the same cycle
    bus_write(4'h0, 32'h3200_0000);
    @(negedge clk);
    lut_sel   = 9'd50;
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = 4'h4;
    req_wdata = 32'hC300_0000;
    #1;
    check("R8 old colour during write", {8'h0, lut_rgb}, 32'(model_rgb(50)));
    mr[50] = 32'hC3;
    model_advance();
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    #1;
    check("R8 new colour one cycle later", {8'h0, lut_rgb}, 32'(model_rgb(50)));

    // full table sweep against the model
    begin
      int bad;
      bad = 0;
      for (int e = 0; e < 260; e++) begin
        lut_sel = 9'(e);
        #1;
        if ({8'h0, lut_rgb} !== 32'(model_rgb(e))) bad++;
      end
      check("R7 full table matches model (mismatch count)", 32'(bad), 32'h0);
    end

    repeat (3) @(negedge clk);
    check("R6 all responses received", 32'(exp_q.size()), 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule